// File: doc/BRIEF.md
# ATM Cell Transmit Formatter

This block produces an unbroken stream of 53-octet ATM cells, one octet per clock, for a line framer. At every cell boundary it looks at a cell-ready flag from the ATM-layer source. When a source cell is ready, the block reads that cell one octet per cycle for 53 cycles. When none is ready, it generates an idle cell. Idle cells take their header from a programmed idle-header word and fill the payload with a programmed idle octet.

For data cells, any of the five ATM header fields (GFC, VPI, VCI, PTI, CLP) can be replaced by the matching field of a replacement-header word. The fifth octet can be filled with a freshly computed HEC, with an HEC corrupted on purpose by an error pattern, or with the octet the source supplied. Payload octets of both data and idle cells can pass through a self-synchronising x^43+1 scrambler. Header and HEC octets are never scrambled. All controls are static inputs.

Top module: `atm_cell_tx_fmt`

## Requirements
- R1: While reset is held, `out_vld`, `out_sof` and `src_rd` are 0. After reset, `out_vld` is 1 on every cycle. `out_sof` marks the first octet of each cell, and consecutive `out_sof` pulses are exactly 53 cycles apart.
- R2: Output octet 4 (counting from 0) of a data cell with `hec_dis`=0 and `hec_err`=0 is the CRC-8 of the four transmitted header octets, XORed with 0x55. The CRC uses generator x^8+x^2+x+1, a zero preset, and processes bits MSB first. An all-zero header gives 0x55.
- R3: With `hec_dis`=1, octet 4 of a data cell is the octet the source supplied in that position, unchanged.
- R4: With `hec_dis`=0 and `hec_err`=1, octet 4 of a data cell is the R2 value XORed with `err_pat`. Idle cells always carry the uncorrupted R2 value, whatever `hec_dis` and `hec_err` are set to.
- R5: If `src_cell_rdy` is 0 at a cell boundary, an idle cell is sent. Its header octets are `idle_hdr[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` in that order. Its octet 4 is the R2 HEC of that header. With scrambling off, all 48 payload octets equal `idle_pay`. `out_idle` is 1 throughout the cell.
- R6: In data cells, each `hdr_sel` bit replaces one header field with the matching bits of `rep_hdr`. The header word is sent MSB octet first, and the bit assignments are: bit 0 selects GFC (header bits 31:28), bit 1 VPI (27:20), bit 2 VCI (19:4), bit 3 PTI (3:1), and bit 4 CLP (bit 0). The HEC is computed over the header as modified.
- R7: With `scr_en`=1, each payload bit, taken MSB first, leaves as y(t) = x(t) XOR y(t-43). The scrambler history advances only on payload octets sent while `scr_en`=1, and it carries across cells. Header and HEC octets are never scrambled.
- R8: With `hdr_sel`=0, `hec_dis`=1 and `scr_en`=0, all 53 output octets of a data cell equal the 53 source octets in order.
- R9: The choice between a data cell and an idle cell is made only at a cell boundary. `src_rd` is 1 for exactly 53 consecutive cycles per accepted cell, starting at the cell's first octet. If `src_cell_rdy` is raised partway through an idle cell, that idle cell still completes unchanged.
- R10: `src_data` is taken in the same cycle that `src_rd` is 1. The resulting octet appears on `out_data` one cycle later. `out_idle` is 0 for every octet of a data cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_cell_rdy | input | 1 | Source holds a complete cell |
| src_data | input | 8 | Current source octet, read while src_rd is 1 |
| src_rd | output | 1 | Source octet consumed this cycle |
| hec_dis | input | 1 | 1: pass the source HEC octet through |
| hec_err | input | 1 | 1: XOR err_pat into the computed HEC |
| err_pat | input | 8 | HEC corruption pattern |
| scr_en | input | 1 | Payload scrambler enable |
| hdr_sel | input | 5 | Per-field header replacement select |
| rep_hdr | input | 32 | Replacement header word |
| idle_hdr | input | 32 | Idle-cell header word |
| idle_pay | input | 8 | Idle-cell payload octet |
| out_data | output | 8 | Transmitted octet |
| out_vld | output | 1 | Stream running |
| out_sof | output | 1 | First octet of a cell |
| out_idle | output | 1 | Current octet belongs to an idle cell |

## Verification
The embedded assertions check on every cycle that cells are 53 cycles apart and that a source read always starts at a cell boundary and runs without a gap until the cell ends. They also check that `out_idle` follows the previous cycle's read strobe, and that a disabled HEC passes the source octet through. The numeric results can only be shown by the bench scenarios. These are the HEC value against known headers, the error-pattern XOR, field-by-field header replacement, idle-cell contents, the scrambler relation (checked by descrambling a cell), and a source cell that arrives mid-cell without disturbing the idle cell in progress.

// File: rtl/atm_cell_tx_fmt.sv
module atm_cell_tx_fmt #(
  parameter int          CELL_LEN  = 53,
  parameter int          SCR_TAP   = 43,
  parameter logic [7:0]  CRC_POLY  = 8'h07,
  parameter logic [7:0]  HEC_COSET = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_cell_rdy,
  input  logic [7:0]  src_data,
  output logic        src_rd,
  input  logic        hec_dis,
  input  logic        hec_err,
  input  logic [7:0]  err_pat,
  input  logic        scr_en,
  input  logic [4:0]  hdr_sel,
  input  logic [31:0] rep_hdr,
  input  logic [31:0] idle_hdr,
  input  logic [7:0]  idle_pay,
  output logic [7:0]  out_data,
  output logic        out_vld,
  output logic        out_sof,
  output logic        out_idle
);

  localparam int CNT_W = $clog2(CELL_LEN);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(CELL_LEN - 1);
  localparam logic [CNT_W-1:0] HEC_AT = CNT_W'(4);

  logic [CNT_W-1:0]   cnt;
  logic               data_q;
  logic [7:0]         crc_q;
  logic [SCR_TAP-1:0] scr_q, scr_nxt;
  logic [7:0]         scr_oct;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ CRC_POLY;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] octet_of(input logic [31:0] w, input logic [1:0] k);
    case (k)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  wire        at_start = (cnt == '0);
  wire        in_hdr   = (cnt < HEC_AT);
  wire        at_hec   = (cnt == HEC_AT);
  wire        in_pay   = (cnt > HEC_AT);
  wire        cur_data = at_start ? src_cell_rdy : data_q;

  assign src_rd = rst_n & cur_data;

  wire [31:0] rep_mask = {{4{hdr_sel[0]}}, {8{hdr_sel[1]}}, {16{hdr_sel[2]}},
                          {3{hdr_sel[3]}}, hdr_sel[4]};
  wire [7:0]  msk_oct  = octet_of(rep_mask, cnt[1:0]);
  wire [7:0]  rep_oct  = octet_of(rep_hdr, cnt[1:0]);
  wire [7:0]  hdr_oct  = cur_data ? ((src_data & ~msk_oct) | (rep_oct & msk_oct))
                                  : octet_of(idle_hdr, cnt[1:0]);

  wire [7:0]  hec_val  = crc_q ^ HEC_COSET;
  wire [7:0]  hec_oct  = !cur_data ? hec_val :
                         hec_dis   ? src_data :
                         hec_val ^ (hec_err ? err_pat : 8'h00);

  wire [7:0]  pay_raw  = cur_data ? src_data : idle_pay;
  wire [7:0]  pay_oct  = scr_en ? scr_oct : pay_raw;

  always_comb begin
    logic [SCR_TAP-1:0] s;
    logic               b;
    s = scr_q;
    for (int i = 7; i >= 0; i--) begin
      b          = pay_raw[i] ^ s[SCR_TAP-1];
      s          = {s[SCR_TAP-2:0], b};
      scr_oct[i] = b;
    end
    scr_nxt = s;
  end

  wire [7:0] nxt_oct = in_hdr ? hdr_oct : at_hec ? hec_oct : pay_oct;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      data_q   <= 1'b0;
      crc_q    <= '0;
      scr_q    <= '0;
      out_data <= '0;
      out_vld  <= 1'b0;
      out_sof  <= 1'b0;
      out_idle <= 1'b0;
    end else begin
      cnt      <= (cnt == LAST) ? '0 : cnt + 1'b1;
      data_q   <= cur_data;
      if (at_start)    crc_q <= crc_step(8'h00, hdr_oct);
      else if (in_hdr) crc_q <= crc_step(crc_q, hdr_oct);
      if (in_pay && scr_en) scr_q <= scr_nxt;
      out_data <= nxt_oct;
      out_vld  <= 1'b1;
      out_sof  <= at_start;
      out_idle <= !cur_data;
    end
  end

  logic [CNT_W:0] chk_gap;
  logic           chk_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_gap  <= '0;
      chk_seen <= 1'b0;
    end else begin
      if (out_sof) begin
        chk_gap  <= (CNT_W+1)'(1);
        chk_seen <= 1'b1;
      end else if (chk_gap != '1) begin
        chk_gap <= chk_gap + 1'b1;
      end
    end
  end

  AST_SOF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && chk_seen) |-> (chk_gap == (CNT_W+1)'(CELL_LEN))); // R1
  AST_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_rd) |=> out_sof); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && cnt != LAST) |=> src_rd); // R9
  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_idle == !$past(src_rd))); // R10
  AST_HEC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (at_hec && src_rd && hec_dis) |=> (out_data == $past(src_data))); // R3

endmodule

// File: tb/atm_cell_tx_fmt_bench.sv
`timescale 1ns/1ps
module atm_cell_tx_fmt_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        src_rd, hec_dis, hec_err, scr_en;
  logic [7:0]  err_pat, idle_pay, out_data;
  logic [4:0]  hdr_sel;
  logic [31:0] rep_hdr, idle_hdr;
  logic        out_vld, out_sof, out_idle;
  logic [7:0]  sbuf [53];
  logic [5:0]  sidx;
  int          req = 0, taken = 0, rd_total = 0;
  wire         src_cell_rdy = (req != taken);
  wire [7:0]   src_data = sbuf[sidx];

  atm_cell_tx_fmt u_atm_cell_tx_fmt (
    .clk(clk), .rst_n(rst_n), .src_cell_rdy(src_cell_rdy), .src_data(src_data),
    .src_rd(src_rd), .hec_dis(hec_dis), .hec_err(hec_err), .err_pat(err_pat),
    .scr_en(scr_en), .hdr_sel(hdr_sel), .rep_hdr(rep_hdr), .idle_hdr(idle_hdr),
    .idle_pay(idle_pay), .out_data(out_data), .out_vld(out_vld),
    .out_sof(out_sof), .out_idle(out_idle));

  always_ff @(posedge clk) begin
    if (!rst_n) sidx <= '0;
    else if (src_rd) begin
      sidx <= (sidx == 6'd52) ? 6'd0 : sidx + 6'd1;
      if (sidx == 6'd0) taken <= taken + 1;
      rd_total <= rd_total + 1;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] got [53];
  logic       g_idle;

  localparam logic [39:0] HEC_VEC [4] = '{
    {32'h0000_0000, 8'h55}, {32'h0000_0001, 8'h52},
    {32'h0000_0002, 8'h5B}, {32'h0000_0080, 8'hDC}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int b = 31; b >= 0; b--) begin
      logic top = c[7] ^ h[b];
      c = c << 1;
      if (top) c = c ^ 8'h07;
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [31:0] mix(input logic [31:0] s, input logic [31:0] r, input logic [4:0] m);
    return {m[0] ? r[31:28] : s[31:28], m[1] ? r[27:20] : s[27:20],
            m[2] ? r[19:4]  : s[19:4],  m[3] ? r[3:1]   : s[3:1],
            m[4] ? r[0]     : s[0]};
  endfunction

  task automatic grab();
    do @(negedge clk); while (!out_sof);
    g_idle = out_idle;
    got[0] = out_data;
    for (int k = 1; k < 53; k++) begin
      @(negedge clk);
      got[k] = out_data;
    end
  endtask

  task automatic load(input logic [31:0] h);
    sbuf[0] = h[31:24]; sbuf[1] = h[23:16]; sbuf[2] = h[15:8]; sbuf[3] = h[7:0];
    sbuf[4] = 8'hA7;
    for (int k = 5; k < 53; k++) sbuf[k] = 8'((k * 37 + 11) ^ h[7:0]);
  endtask

  task automatic send(input logic [31:0] h);
    @(negedge clk);
    load(h);
    req++;
    for (int t = 0; t < 4; t++) begin
      grab();
      if (!g_idle) break;
    end
  endtask

  function automatic logic [31:0] got_hdr();
    return {got[0], got[1], got[2], got[3]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] exph;
    logic [7:0]  pbit [384];
    bit          ok;
    int          t0, n, rd0;
    for (int k = 0; k < 53; k++) sbuf[k] = 8'h00;
    hec_dis = 0; hec_err = 0; err_pat = 8'h00; scr_en = 0; hdr_sel = 5'd0;
    rep_hdr = 32'hFEDC_BA98; idle_hdr = 32'h0000_0001; idle_pay = 8'h6A;
    repeat (3) @(negedge clk);
    chk(!out_vld && !out_sof && !src_rd, "R1 reset outputs", {out_vld, out_sof, src_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_vld && out_sof, "R1 stream starts", {out_vld, out_sof}, 3);

    grab();
    ok = g_idle && got_hdr() == idle_hdr;
    for (int k = 5; k < 53; k++) if (got[k] != idle_pay) ok = 0;
    chk(ok, "R5 idle header and payload", got_hdr(), idle_hdr);
    chk(got[4] == 8'h52, "R5 idle HEC", got[4], 8'h52);

    for (int v = 0; v < 4; v++) begin
      send(HEC_VEC[v][39:8]);
      chk(!g_idle && got[4] == HEC_VEC[v][7:0], "R2 HEC vector", got[4], HEC_VEC[v][7:0]);
    end
    send(32'h1234_5678);
    chk(got[4] == hec_of(32'h1234_5678), "R2 HEC model", got[4], hec_of(32'h1234_5678));

    hec_dis = 1;
    send(32'hCAFE_0042);
    chk(got[4] == 8'hA7, "R3 HEC passthrough", got[4], 8'hA7);
    ok = 1;
    for (int k = 0; k < 53; k++) if (got[k] != sbuf[k]) ok = 0;
    chk(ok, "R8 transparent cell", got[20], sbuf[20]);

    hec_dis = 0; hec_err = 1; err_pat = 8'h3C;
    send(32'h0ABC_DEF0);
    chk(got[4] == (hec_of(32'h0ABC_DEF0) ^ 8'h3C), "R4 corrupted HEC", got[4], hec_of(32'h0ABC_DEF0) ^ 8'h3C);
    idle_hdr = 32'h0055_AA0F;
    grab();
    chk(g_idle && got[4] == hec_of(32'h0055_AA0F), "R4 idle HEC clean", got[4], hec_of(32'h0055_AA0F));
    hec_err = 0;

    hdr_sel = 5'b00100;
    send(32'h1111_1111);
    exph = mix(32'h1111_1111, rep_hdr, 5'b00100);
    chk(got_hdr() == exph, "R6 VCI replaced", got_hdr(), exph);
    chk(got[4] == hec_of(exph), "R6 HEC over new header", got[4], hec_of(exph));
    hdr_sel = 5'b11001;
    send(32'h2345_6789);
    exph = mix(32'h2345_6789, rep_hdr, 5'b11001);
    chk(got_hdr() == exph, "R6 GFC/PTI/CLP replaced", got_hdr(), exph);
    hdr_sel = 5'd0;

    scr_en = 1;
    send(32'h0F0F_F0F0);
    chk(got_hdr() == 32'h0F0F_F0F0 && got[4] == hec_of(32'h0F0F_F0F0), "R7 header unscrambled", got_hdr(), 32'h0F0F_F0F0);
    for (int j = 0; j < 48; j++)
      for (int i = 0; i < 8; i++) pbit[j*8+i] = {7'd0, got[5+j][7-i]};
    ok = 1;
    for (int j = 6; j < 48; j++)
      for (int i = 0; i < 8; i++)
        if ((pbit[j*8+i][0] ^ pbit[j*8+i-43][0]) != sbuf[5+j][7-i]) ok = 0;
    chk(ok, "R7 descrambled payload", got[30], sbuf[30]);
    ok = 0;
    for (int j = 6; j < 48; j++) if (got[5+j] != sbuf[5+j]) ok = 1;
    chk(ok, "R7 payload altered", got[30], sbuf[30]);
    scr_en = 0;

    load(32'h7777_0000);
    do @(negedge clk); while (!(out_sof && out_idle));
    g_idle = out_idle; got[0] = out_data;
    for (int k = 1; k < 53; k++) begin
      if (k == 10) req++;
      @(negedge clk);
      got[k] = out_data;
      if (!out_idle) g_idle = 0;
    end
    ok = g_idle;
    for (int k = 5; k < 53; k++) if (got[k] != idle_pay) ok = 0;
    chk(ok, "R9 mid-cell request waits", got[40], idle_pay);
    rd0 = rd_total;
    t0 = 0; n = 0;
    grab();
    chk(!g_idle && got_hdr() == 32'h7777_0000, "R10 data cell follows", got_hdr(), 32'h7777_0000);
    chk(rd_total - rd0 == 53, "R9 read length", rd_total - rd0, 53);

    do @(negedge clk); while (!out_sof);
    do begin @(negedge clk); n++; end while (!out_sof);
    chk(n == 53, "R1 cell spacing", n, 53);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule